// File: doc/BRIEF.md
# Smart Card Character Receiver with Error Status

This block takes the serial I/O line of a smart card and turns it into bytes. A character is a low start bit, eight data bits sent least significant bit first, one parity bit and a high guard/stop level. All timing is counted in elementary time units (ETUs). One ETU is `ETU_TICKS` pulses of the `tick` input, so the host sets the bit rate by how often it pulses `tick`. Good characters go into an eight-entry receive FIFO. The oldest entry is always visible on `rx_data`, and the host removes it with `rx_pop`.

Three sticky flags report line problems: parity, framing and overrun. Each is posted 10.5 ETU after the start edge. Any set flag raises `irq`. A one-cycle `stat_rd` pulse reads the flags and clears them. The protocol bit latched by `cfg_load` selects the parity policy. Under T=0 a bad character is dropped and counted against a 3-bit limit. Under T=1 every character is kept and the first parity error is flagged.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, all three flags and `irq` are 0, `rx_empty` is 1 and `rx_full` is 0.
- R2: A frame is: start bit low, eight data bits least significant first, parity bit, then the line high at 10.25 ETU. Parity is even: the XOR of the eight data bits and the parity bit is 0. A correct frame is stored, and `rx_data` returns characters in arrival order.
- R3: With T=0 selected (`cfg_t1`=0 at the last `cfg_load`), a character whose parity is wrong is not written to the FIFO.
- R4: With T=0, each wrong-parity character adds one to an error count. The parity flag is set only when the count becomes greater than `cfg_limit`. A `cfg_load` pulse clears the count.
- R5: With T=1, one wrong-parity character sets the parity flag, and that character is still stored.
- R6: If the line is low at 10.25 ETU, the framing flag is set. The parity flag can be set by the same character.
- R7: Flags from a character change 10.5 ETU after its start edge and not earlier. At 10.25 ETU they still hold their old value.
- R8: If a character should be stored but the FIFO is full in the posting cycle, the character is discarded, the FIFO contents stay unchanged, and the overrun flag is set.
- R9: A `stat_rd` pulse clears all flags on the next cycle. A flag being set in the same cycle as the read stays set.
- R10: `irq` is 1 exactly while at least one flag is 1.
- R11: A low pulse on the line that has returned high by 0.5 ETU is ignored: nothing is stored and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sub-ETU timing strobe, ETU_TICKS per ETU |
| line_in | input | 1 | Card I/O line, idle high |
| cfg_load | input | 1 | Latch protocol and limit, clear T=0 error count |
| cfg_t1 | input | 1 | 1 selects T=1 parity policy, 0 selects T=0 |
| cfg_limit | input | 3 | Allowed T=0 parity errors before flagging |
| stat_rd | input | 1 | Status read strobe, clears flags |
| flag_parity | output | 1 | Parity error flag |
| flag_frame | output | 1 | Framing error flag |
| flag_overrun | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt, any flag set |
| rx_pop | input | 1 | Remove oldest FIFO entry |
| rx_data | output | 8 | Oldest FIFO entry |
| rx_empty | output | 1 | FIFO holds no characters |
| rx_full | output | 1 | FIFO holds DEPTH characters |

## Verification
The hardest case to reach from the ports is a status read that lands on the exact cycle a flag is posted. The bench holds `stat_rd` high across the whole posting window of a bad-parity T=1 character. It releases the strobe in the half cycle right after it first sees the flag, then checks that the flag survived. The T=0 limit also needs a planned sequence: several bad characters, a `cfg_load` in the middle to restart the count, and the FIFO staying empty throughout. Overrun needs the FIFO filled to its last slot first, then the oldest-first contents compared after one more character.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  localparam int CHAR_BITS = 8;
  localparam logic [3:0] STOP_SLOT = 4'd10;

  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_t;

  // even parity over data and parity bit: result 1 means correct
  function automatic logic even_ok(input logic [CHAR_BITS-1:0] d, input logic p);
    return ~(^{d, p});
  endfunction

  // slots 1..9 carry data bits then parity
  function automatic logic is_payload(input logic [3:0] slot);
    return (slot >= 4'd1) && (slot <= 4'd9);
  endfunction

  // saturating increment of the T=0 error count
  function automatic logic [3:0] count_up(input logic [3:0] c);
    return (c == 4'hF) ? c : c + 4'd1;
  endfunction

  // T=0 limit test: exceeded when count is strictly above limit
  function automatic logic over_limit(input logic [3:0] c, input logic [2:0] lim);
    return c > {1'b0, lim};
  endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      dout <= 1'b1;
    end else begin
      s1   <= din;
      dout <= s1;
    end
  end
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_rx_pkg::*;
#(
  parameter int ETU_TICKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  output logic                 done,
  output logic [CHAR_BITS-1:0] data,
  output logic                 par_bad,
  output logic                 stop_bad
);
  localparam int PW = (ETU_TICKS > 2) ? $clog2(ETU_TICKS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(ETU_TICKS - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(ETU_TICKS / 2);
  localparam logic [PW-1:0] PH_QTR  = PW'(ETU_TICKS / 4);

  rx_state_t      st;
  logic [PW-1:0]  phase, ph_nxt;
  logic [3:0]     slot, slot_nxt;
  logic           line_prev;
  logic [CHAR_BITS:0] shreg;

  always_comb begin
    ph_nxt   = (phase == PH_LAST) ? '0 : phase + 1'b1;
    slot_nxt = (phase == PH_LAST) ? slot + 4'd1 : slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      phase     <= '0;
      slot      <= '0;
      line_prev <= 1'b1;
      shreg     <= '0;
      stop_bad  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        line_prev <= line;
        if (st == RX_IDLE) begin
          if (line_prev && !line) begin
            st    <= RX_BUSY;
            phase <= '0;
            slot  <= '0;
          end
        end else begin
          phase <= ph_nxt;
          slot  <= slot_nxt;
          if (slot_nxt == 4'd0 && ph_nxt == PH_HALF && line)
            st <= RX_IDLE;
          if (is_payload(slot_nxt) && ph_nxt == PH_HALF)
            shreg <= {line, shreg[CHAR_BITS:1]};
          if (slot_nxt == STOP_SLOT && ph_nxt == PH_QTR)
            stop_bad <= !line;
          if (slot_nxt == STOP_SLOT && ph_nxt == PH_HALF) begin
            done <= 1'b1;
            st   <= RX_IDLE;
          end
        end
      end
    end
  end

  assign data    = shreg[CHAR_BITS-1:0];
  assign par_bad = !even_ok(shreg[CHAR_BITS-1:0], shreg[CHAR_BITS]);

endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp, rp;
  logic             do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (do_push && wp[AW-1:0] == AW'(i))
        mem[i] <= wdata;
    end
  end
endmodule

// File: rtl/sc_rx_errstat.sv
module sc_rx_errstat
  import sc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_done,
  input  logic       par_bad,
  input  logic       stop_bad,
  input  logic       fifo_full,
  input  logic       cfg_load,
  input  logic       cfg_t1,
  input  logic [2:0] cfg_limit,
  input  logic       stat_rd,
  output logic       t1_q,
  output logic       want_store,
  output logic       fifo_push,
  output logic       flag_parity,
  output logic       flag_frame,
  output logic       flag_overrun
);
  logic [2:0] limit_q;
  logic [3:0] perr_cnt, cnt_nxt;
  logic       t0_err, pe_hit, fe_hit, ovr_hit;

  assign t0_err     = char_done && par_bad && !t1_q;
  assign cnt_nxt    = count_up(perr_cnt);
  assign want_store = char_done && (t1_q || !par_bad);
  assign fifo_push  = want_store && !fifo_full;
  assign ovr_hit    = want_store && fifo_full;
  assign fe_hit     = char_done && stop_bad;
  assign pe_hit     = char_done && par_bad &&
                      (t1_q || over_limit(cnt_nxt, limit_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_q     <= 1'b0;
      limit_q  <= '0;
      perr_cnt <= '0;
    end else if (cfg_load) begin
      t1_q     <= cfg_t1;
      limit_q  <= cfg_limit;
      perr_cnt <= '0;
    end else if (t0_err) begin
      perr_cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_parity  <= 1'b0;
      flag_frame   <= 1'b0;
      flag_overrun <= 1'b0;
    end else begin
      flag_parity  <= (flag_parity  && !stat_rd) || pe_hit;
      flag_frame   <= (flag_frame   && !stat_rd) || fe_hit;
      flag_overrun <= (flag_overrun && !stat_rd) || ovr_hit;
    end
  end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_rx_pkg::*;
#(
  parameter int ETU_TICKS  = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  input  logic       cfg_load,
  input  logic       cfg_t1,
  input  logic [2:0] cfg_limit,
  input  logic       stat_rd,
  output logic       flag_parity,
  output logic       flag_frame,
  output logic       flag_overrun,
  output logic       irq,
  input  logic       rx_pop,
  output logic [7:0] rx_data,
  output logic       rx_empty,
  output logic       rx_full
);
  logic                 line_s;
  logic                 char_done, par_bad, stop_bad;
  logic [CHAR_BITS-1:0] char_data;
  logic                 t1_q, want_store, fifo_push, fifo_full;

  sc_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s)
  );

  sc_rx_frame #(.ETU_TICKS(ETU_TICKS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .done(char_done), .data(char_data), .par_bad(par_bad), .stop_bad(stop_bad)
  );

  sc_rx_errstat u_stat (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .par_bad(par_bad),
    .stop_bad(stop_bad), .fifo_full(fifo_full), .cfg_load(cfg_load),
    .cfg_t1(cfg_t1), .cfg_limit(cfg_limit), .stat_rd(stat_rd),
    .t1_q(t1_q), .want_store(want_store), .fifo_push(fifo_push),
    .flag_parity(flag_parity), .flag_frame(flag_frame),
    .flag_overrun(flag_overrun)
  );

  sc_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_BITS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(char_data),
    .pop(rx_pop), .head(rx_data), .empty(rx_empty), .full(fifo_full)
  );

  assign rx_full = fifo_full;
  assign irq     = flag_parity || flag_frame || flag_overrun;

endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic char_done,
  input logic par_bad,
  input logic stop_bad,
  input logic t1_q,
  input logic want_store,
  input logic fifo_push,
  input logic fifo_full,
  input logic stat_rd,
  input logic flag_parity,
  input logic flag_frame,
  input logic flag_overrun,
  input logic irq
);
  assert_t0_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && !t1_q && par_bad |-> !fifo_push);

  assert_t1_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && t1_q && par_bad && !fifo_full |-> fifo_push);

  assert_t1_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && t1_q && par_bad |=> flag_parity);

  assert_frame_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && stop_bad |=> flag_frame);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    want_store && fifo_full |=> flag_overrun);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !char_done |=> !flag_parity && !flag_frame && !flag_overrun);

  assert_post_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_frame) || $rose(flag_parity) || $rose(flag_overrun) |-> $past(char_done));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(char_done));
endmodule

bind sc_char_rx sc_char_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .char_done(char_done), .par_bad(par_bad),
  .stop_bad(stop_bad), .t1_q(t1_q), .want_store(want_store),
  .fifo_push(fifo_push), .fifo_full(fifo_full), .stat_rd(stat_rd),
  .flag_parity(flag_parity), .flag_frame(flag_frame),
  .flag_overrun(flag_overrun), .irq(irq)
);

// File: tb/sc_char_rx_test.sv
module sc_char_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int ETU_TICKS  = 8;
  localparam int ETU_CYC    = 2 * ETU_TICKS;

  logic       clk = 0, rst_n = 0, tick = 0, line_in = 1;
  logic       cfg_load = 0, cfg_t1 = 0, stat_rd = 0, rx_pop = 0;
  logic [2:0] cfg_limit = 0;
  logic       flag_parity, flag_frame, flag_overrun, irq;
  logic [7:0] rx_data;
  logic       rx_empty, rx_full;
  int checks = 0, errors = 0;

  sc_char_rx #(.ETU_TICKS(ETU_TICKS), .FIFO_DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .cfg_load(cfg_load), .cfg_t1(cfg_t1), .cfg_limit(cfg_limit),
    .stat_rd(stat_rd), .flag_parity(flag_parity), .flag_frame(flag_frame),
    .flag_overrun(flag_overrun), .irq(irq), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive start, data LSB first, parity; stop level left on line
  task automatic send_head(input logic [7:0] d, input bit flip, input bit stop_low);
    line_in = 0; wait_cyc(ETU_CYC);
    for (int i = 0; i < 8; i++) begin
      line_in = d[i]; wait_cyc(ETU_CYC);
    end
    line_in = (^d) ^ flip; wait_cyc(ETU_CYC);
    line_in = !stop_low;
  endtask

  task automatic send_char(input logic [7:0] d, input bit flip, input bit stop_low);
    send_head(d, flip, stop_low);
    wait_cyc(ETU_CYC);
    line_in = 1;
    wait_cyc(2 * ETU_CYC);
  endtask

  task automatic configure(input bit t1, input logic [2:0] lim);
    cfg_t1 = t1; cfg_limit = lim; cfg_load = 1;
    wait_cyc(1);
    cfg_load = 0;
  endtask

  task automatic read_clear();
    stat_rd = 1; wait_cyc(1); stat_rd = 0; wait_cyc(1);
  endtask

  task automatic drain();
    while (!rx_empty) begin
      rx_pop = 1; wait_cyc(1); rx_pop = 0;
    end
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string req);
    check(!rx_empty && rx_data == exp, req, rx_data, exp);
    rx_pop = 1; wait_cyc(1); rx_pop = 0;
  endtask

  task automatic t_reset();
    check(!flag_parity && !flag_frame && !flag_overrun, "R1 flags", {flag_parity, flag_frame, flag_overrun}, 0);
    check(!irq, "R1 irq", irq, 0);
    check(rx_empty && !rx_full, "R1 fifo", {rx_empty, rx_full}, 2);
  endtask

  task automatic t_good();
    configure(1'b0, 3'd0);
    send_char(8'hA5, 0, 0);
    send_char(8'h3C, 0, 0);
    check(!irq, "R2 no flag on clean chars", irq, 0);
    pop_expect(8'hA5, "R2 first");
    pop_expect(8'h3C, "R2 second");
    check(rx_empty, "R2 empty after pops", rx_empty, 1);
  endtask

  task automatic t_t0();
    configure(1'b0, 3'd1);
    send_char(8'h81, 1, 0);
    check(rx_empty, "R3 bad char dropped", rx_empty, 1);
    check(!flag_parity, "R4 first error within limit", flag_parity, 0);
    send_char(8'h42, 1, 0);
    check(flag_parity, "R4 second error exceeds limit", flag_parity, 1);
    check(irq, "R10 irq with flag", irq, 1);
    check(rx_empty, "R3 still dropped", rx_empty, 1);
    read_clear();
    check(!flag_parity && !irq, "R9 read clears", {flag_parity, irq}, 0);
    configure(1'b0, 3'd1);
    send_char(8'h11, 1, 0);
    check(!flag_parity, "R4 count cleared by cfg_load", flag_parity, 0);
  endtask

  task automatic t_t1();
    configure(1'b1, 3'd7);
    send_char(8'h5A, 1, 0);
    check(flag_parity, "R5 single error flags", flag_parity, 1);
    check(!flag_frame, "R5 no framing", flag_frame, 0);
    pop_expect(8'h5A, "R5 bad char kept");
    read_clear();
  endtask

  task automatic t_frame();
    configure(1'b1, 3'd0);
    send_char(8'h6E, 0, 1);
    check(flag_frame && !flag_parity, "R6 framing only", {flag_frame, flag_parity}, 2);
    pop_expect(8'h6E, "R6 stored");
    read_clear();
    send_char(8'h19, 1, 1);
    check(flag_frame && flag_parity, "R6 both flags", {flag_frame, flag_parity}, 3);
    drain();
    read_clear();
  endtask

  task automatic t_timing();
    configure(1'b1, 3'd0);
    send_head(8'hC3, 1, 0);
    wait_cyc(ETU_CYC / 4);
    check(!flag_parity, "R7 not yet at 10.25 ETU", flag_parity, 0);
    wait_cyc(ETU_CYC);
    check(flag_parity, "R7 posted by 11.25 ETU", flag_parity, 1);
    line_in = 1;
    wait_cyc(2 * ETU_CYC);
    drain();
    read_clear();
  endtask

  task automatic t_overrun();
    configure(1'b1, 3'd0);
    drain();
    for (int i = 0; i < 8; i++) send_char(8'(i * 17 + 3), 0, 0);
    check(rx_full && !flag_overrun, "R8 full, no overrun yet", {rx_full, flag_overrun}, 2);
    send_char(8'hEE, 0, 0);
    check(flag_overrun, "R8 overrun set", flag_overrun, 1);
    for (int i = 0; i < 8; i++) pop_expect(8'(i * 17 + 3), "R8 contents kept");
    check(rx_empty, "R8 extra char lost", rx_empty, 1);
    read_clear();
  endtask

  task automatic t_read_race();
    bit seen = 0;
    configure(1'b1, 3'd0);
    send_head(8'h27, 1, 0);
    stat_rd = 1;
    for (int i = 0; i < 40 && !seen; i++) begin
      wait_cyc(1);
      if (flag_parity) seen = 1;
    end
    stat_rd = 0;
    check(seen, "R9 flag set during read", seen, 1);
    wait_cyc(1);
    check(flag_parity, "R9 set wins over read", flag_parity, 1);
    line_in = 1;
    wait_cyc(2 * ETU_CYC);
    drain();
    read_clear();
  endtask

  task automatic t_glitch();
    configure(1'b1, 3'd0);
    line_in = 0; wait_cyc(4); line_in = 1;
    wait_cyc(12 * ETU_CYC);
    check(rx_empty, "R11 nothing stored", rx_empty, 1);
    check(!irq, "R11 no flag", irq, 0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1;
    wait_cyc(4);
    t_reset();
    t_good();
    t_t0();
    t_t1();
    t_frame();
    t_timing();
    t_overrun();
    t_read_race();
    t_glitch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule